// File: doc/BRIEF.md
# Confidence-Gated Last-Value Predictor

This block guesses the result of an instruction before it executes. For each instruction address it keeps the last result seen, held in a value table. A second, smaller table holds a saturating confidence counter for each address. Lookup is purely combinational on the fetch address. It returns the stored result and a flag that tells the pipeline whether the guess is worth forwarding. Once the real result is known, the pipeline presents the address and the computed value on the update port. In that cycle the block trains the confidence counter and may overwrite the stored result.

The value table is direct-mapped. Each entry holds a valid bit and a partial tag, formed by XOR-folding every address bit above the index down to the tag width. The confidence table is indexed separately, from the low word-address bits, so several addresses can share one counter.

Each counter is a four-state machine, updated only by update cycles:
- CF_COLD (0) and CF_WARM (1): the prediction is not used.
- CF_TRUST (2): the prediction is used.
- CF_LOCK (3): the prediction is used, and the stored value is kept even after a wrong guess.

Transitions: *promote* on a matching result (saturating at CF_LOCK), *demote* on a mismatch (saturating at CF_COLD), and *restart* to CF_COLD when an address allocates a value entry.

Top module: `cvp_predictor`

## Requirements
- R1: After reset, a lookup at any address returns lk_use=0 and lk_value=0. Reset clears every valid bit and sets every counter to CF_COLD.
- R2: An update whose address misses in the value table (entry not valid, or tag differs) does three things. It allocates the entry, stores the result, and sets the counter for that address to CF_COLD. A later lookup at that address returns the result with lk_use=0.
- R3: An update whose address hits and whose result equals the stored value raises the counter by one, saturating at CF_LOCK (3).
- R4: An update whose address hits and whose result differs from the stored value lowers the counter by one, saturating at CF_COLD (0).
- R5: A lookup that hits returns lk_use=1 exactly when the counter is CF_TRUST or CF_LOCK. Otherwise lk_use is 0.
- R6: On a hit with a mismatching result, if the counter before the update was below CF_LOCK, the stored value is replaced by the new result.
- R7: On a hit with a mismatching result, if the counter before the update was CF_LOCK, the stored value is kept and the counter becomes CF_TRUST.
- R8: Lookup is combinational. If an update and a lookup target the same entry in one cycle, the lookup returns the old contents, and the new contents appear after that clock edge.
- R9: Value-table index = word-address bits [VI_W+1:2]. Two addresses with the same index that differ in one bit above the index are different tags. A lookup for the non-resident one misses (lk_use=0, lk_value=0), and an update for it evicts the other.
- R10: Confidence index = word-address bits [CI_W+1:2]. Addresses with equal confidence index share one counter, so an allocation by one of them drops the other to lk_use=0 while its stored value is unchanged.
- R11: While upd_valid is 0, the update inputs have no effect on either table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lk_pc | input | PC_W-ALIGN_W (bits PC_W-1..ALIGN_W) | Lookup instruction word address |
| lk_value | output | VAL_W | Predicted result, 0 on a miss |
| lk_use | output | 1 | Prediction is confident enough to forward |
| upd_valid | input | 1 | Update strobe |
| upd_pc | input | PC_W-ALIGN_W (bits PC_W-1..ALIGN_W) | Address of the instruction being trained |
| upd_result | input | VAL_W | Computed result of that instruction |

## Verification
A counter stuck in the wrong state shows at the ports on the very next lookup of that address after an update. lk_use flips against the count of matches and mismatches, and a wrong lock decision leaves lk_value holding the old result, or a new one, one edge after the mismatching update. Tag or index faults show as a hit where a miss is due, or as a vanished entry. Because lookup is combinational, each fault is visible one cycle after the update that caused it. The directed sequences walk every counter state through both saturation limits, so an off-by-one in the counter shows within two updates.

// File: rtl/cvp_pkg.sv
package cvp_pkg;

    // Confidence states; the encoding is the saturating count itself.
    typedef enum logic [1:0] {
        CF_COLD  = 2'd0,
        CF_WARM  = 2'd1,
        CF_TRUST = 2'd2,
        CF_LOCK  = 2'd3
    } conf_state_t;

    function automatic logic conf_use(input conf_state_t s);
        return (s == CF_TRUST) || (s == CF_LOCK);
    endfunction

endpackage

// File: rtl/cvp_conf_fsm.sv
module cvp_conf_fsm
    import cvp_pkg::*;
(
    input  conf_state_t cur_state,
    input  logic        alloc,
    input  logic        match,
    output conf_state_t nxt_state,
    output logic        keep_value
);

    // Next-state: restart on allocation, promote on match, demote on miss.
    always_comb begin
        nxt_state = cur_state;
        if (alloc) begin
            nxt_state = CF_COLD;
        end else begin
            unique case (cur_state)
                CF_COLD:  nxt_state = match ? CF_WARM  : CF_COLD;
                CF_WARM:  nxt_state = match ? CF_TRUST : CF_COLD;
                CF_TRUST: nxt_state = match ? CF_LOCK  : CF_WARM;
                CF_LOCK:  nxt_state = match ? CF_LOCK  : CF_TRUST;
                default:  nxt_state = CF_COLD;
            endcase
        end
    end

    // Output decision: the locked state shields the stored value.
    always_comb begin
        keep_value = 1'b0;
        unique case (cur_state)
            CF_LOCK:  keep_value = !alloc && !match;
            CF_COLD,
            CF_WARM,
            CF_TRUST: keep_value = 1'b0;
            default:  keep_value = 1'b0;
        endcase
    end

endmodule

// File: rtl/cvp_conf_table.sv
module cvp_conf_table
    import cvp_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output conf_state_t      rd_state,
    input  logic [IDX_W-1:0] up_idx,
    output conf_state_t      up_state,
    input  logic             wr_en,
    input  conf_state_t      wr_state
);

    conf_state_t state_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                state_q[i] <= CF_COLD;
            end
        end else if (wr_en) begin
            state_q[up_idx] <= wr_state;
        end
    end

    assign rd_state = state_q[rd_idx];
    assign up_state = state_q[up_idx];

    // R4
    // A demoted counter never climbs: written state is at most read state + 1.
    demote_bound_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (state_q[$past(up_idx)] <= conf_state_t'($past(up_state) + ($past(up_state) != CF_LOCK))))
        else $error("demote_bound_chk");

endmodule

// File: rtl/cvp_value_table.sv
module cvp_value_table #(
    parameter int ENTRIES = 256,
    parameter int TAG_W   = 12,
    parameter int VAL_W   = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             rd_hit,
    output logic [VAL_W-1:0] rd_data,
    input  logic [IDX_W-1:0] up_idx,
    input  logic [TAG_W-1:0] up_tag,
    output logic             up_hit,
    output logic [VAL_W-1:0] up_data,
    input  logic             wr_en,
    input  logic [VAL_W-1:0] wr_data
);

    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q  [ENTRIES];
    logic [VAL_W-1:0]   data_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[up_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[up_idx]  <= up_tag;
            data_q[up_idx] <= wr_data;
        end
    end

    assign rd_hit  = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
    assign rd_data = data_q[rd_idx];
    assign up_hit  = valid_q[up_idx] && (tag_q[up_idx] == up_tag);
    assign up_data = data_q[up_idx];

    // R2
    // A written entry is resident under its tag one edge later.
    write_resident_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (valid_q[$past(up_idx)] && tag_q[$past(up_idx)] == $past(up_tag)))
        else $error("write_resident_chk");

endmodule

// File: rtl/cvp_predictor.sv
module cvp_predictor
    import cvp_pkg::*;
#(
    parameter int PC_W         = 32,
    parameter int ALIGN_W      = 2,
    parameter int VAL_ENTRIES  = 256,
    parameter int CONF_ENTRIES = 64,
    parameter int TAG_W        = 12,
    parameter int VAL_W        = 64
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [PC_W-1:ALIGN_W]   lk_pc,
    output logic [VAL_W-1:0]        lk_value,
    output logic                    lk_use,
    input  logic                    upd_valid,
    input  logic [PC_W-1:ALIGN_W]   upd_pc,
    input  logic [VAL_W-1:0]        upd_result
);

    localparam int VI_W = $clog2(VAL_ENTRIES);
    localparam int CI_W = $clog2(CONF_ENTRIES);
    localparam int WA_W = PC_W - ALIGN_W;
    localparam int UP_W = WA_W - VI_W;

    // Fold every address bit above the index into a short tag.
    function automatic logic [TAG_W-1:0] fold_tag(input logic [UP_W-1:0] up);
        logic [TAG_W-1:0] t;
        t = '0;
        for (int i = 0; i < UP_W; i++) begin
            t[i % TAG_W] = t[i % TAG_W] ^ up[i];
        end
        return t;
    endfunction

    logic [WA_W-1:0]  lk_wa, up_wa;
    logic [VI_W-1:0]  lk_vi, up_vi;
    logic [CI_W-1:0]  lk_ci, up_ci;
    logic [TAG_W-1:0] lk_tag, up_tag;

    assign lk_wa  = lk_pc;
    assign up_wa  = upd_pc;
    assign lk_vi  = lk_wa[VI_W-1:0];
    assign up_vi  = up_wa[VI_W-1:0];
    assign lk_ci  = lk_wa[CI_W-1:0];
    assign up_ci  = up_wa[CI_W-1:0];
    assign lk_tag = fold_tag(lk_wa[WA_W-1:VI_W]);
    assign up_tag = fold_tag(up_wa[WA_W-1:VI_W]);

    logic             lk_hit, up_hit;
    logic [VAL_W-1:0] lk_data, up_data;
    conf_state_t      lk_state, up_state, nxt_state;
    logic             alloc, match, keep_value, val_we;

    assign alloc  = !up_hit;
    assign match  = (up_data == upd_result);
    assign val_we = upd_valid && !keep_value && (alloc || !match);

    cvp_value_table #(
        .ENTRIES (VAL_ENTRIES),
        .TAG_W   (TAG_W),
        .VAL_W   (VAL_W)
    ) u_vtab (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (lk_vi),
        .rd_tag  (lk_tag),
        .rd_hit  (lk_hit),
        .rd_data (lk_data),
        .up_idx  (up_vi),
        .up_tag  (up_tag),
        .up_hit  (up_hit),
        .up_data (up_data),
        .wr_en   (val_we),
        .wr_data (upd_result)
    );

    cvp_conf_table #(
        .ENTRIES (CONF_ENTRIES)
    ) u_ctab (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (lk_ci),
        .rd_state (lk_state),
        .up_idx   (up_ci),
        .up_state (up_state),
        .wr_en    (upd_valid),
        .wr_state (nxt_state)
    );

    cvp_conf_fsm u_fsm (
        .cur_state  (up_state),
        .alloc      (alloc),
        .match      (match),
        .nxt_state  (nxt_state),
        .keep_value (keep_value)
    );

    assign lk_value = lk_hit ? lk_data : '0;
    assign lk_use   = lk_hit && conf_use(lk_state);

    // R5
    use_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
        lk_use |-> (lk_value == lk_data))
        else $error("use_needs_hit_chk");

    // R3
    match_keeps_use_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && lk_pc == upd_pc && lk_use && lk_value == upd_result)
        |=> (!$stable(lk_pc) || lk_use))
        else $error("match_keeps_use_chk");

    // R6
    miss_replaces_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && lk_pc == upd_pc && lk_hit && lk_state != CF_LOCK && lk_value != upd_result)
        |=> (!$stable(lk_pc) || lk_value == $past(upd_result)))
        else $error("miss_replaces_chk");

    // R7
    lock_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && lk_pc == upd_pc && lk_hit && lk_state == CF_LOCK && lk_value != upd_result)
        |=> (!$stable(lk_pc) || ($stable(lk_value) && lk_use)))
        else $error("lock_holds_chk");

    // R2
    alloc_cold_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && lk_pc == upd_pc && !lk_hit)
        |=> (!$stable(lk_pc) || (lk_value == $past(upd_result) && !lk_use)))
        else $error("alloc_cold_chk");

endmodule

// File: tb/cvp_predictor_tb.sv
module cvp_predictor_tb;

    localparam int CLK_PERIOD = 10;
    localparam int PC_W  = 32;
    localparam int VAL_W = 64;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [PC_W-1:2]   lk_pc = '0;
    logic [VAL_W-1:0]  lk_value;
    logic              lk_use;
    logic              upd_valid = 1'b0;
    logic [PC_W-1:2]   upd_pc = '0;
    logic [VAL_W-1:0]  upd_result = '0;

    int checks = 0;
    int errors = 0;

    // Word addresses: A/C share value index 0 and conf index 0;
    // E/D share conf index 16; B stands alone.
    localparam logic [29:0] PA = 30'h400;
    localparam logic [29:0] PC = 30'h500;
    localparam logic [29:0] PB = 30'h023;
    localparam logic [29:0] PE = 30'h010;
    localparam logic [29:0] PD = 30'h050;

    always #(CLK_PERIOD/2) clk = ~clk;

    cvp_predictor u_dut (
        .clk        (clk),
        .rst        (rst),
        .lk_pc      (lk_pc),
        .lk_value   (lk_value),
        .lk_use     (lk_use),
        .upd_valid  (upd_valid),
        .upd_pc     (upd_pc),
        .upd_result (upd_result)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic upd(input logic [29:0] pc, input logic [63:0] res);
        @(negedge clk);
        upd_valid  = 1'b1;
        upd_pc     = pc;
        upd_result = res;
        @(negedge clk);
        upd_valid  = 1'b0;
    endtask

    task automatic look(input logic [29:0] pc, input string req,
                        input logic [63:0] exp_val, input logic exp_use);
        lk_pc = pc;
        #1;
        chk(lk_value == exp_val, req, lk_value, exp_val);
        chk(lk_use == exp_use, req, 64'(lk_use), 64'(exp_use));
    endtask

    task automatic t_reset;
        look(PA, "R1 reset A", 64'h0, 1'b0);
        look(PE, "R1 reset E", 64'h0, 1'b0);
    endtask

    task automatic t_counter_walk;
        upd(PA, 64'h5);  look(PA, "R2 alloc", 64'h5, 1'b0);
        upd(PA, 64'h5);  look(PA, "R3 cold->warm", 64'h5, 1'b0);
        upd(PA, 64'h5);  look(PA, "R5 warm->trust", 64'h5, 1'b1);
        upd(PA, 64'h5);  look(PA, "R3 trust->lock", 64'h5, 1'b1);
        upd(PA, 64'h5);  look(PA, "R3 lock saturates", 64'h5, 1'b1);
        upd(PA, 64'h9);  look(PA, "R7 lock keeps value", 64'h5, 1'b1);
        upd(PA, 64'h9);  look(PA, "R6 trust miss replaces", 64'h9, 1'b0);
        upd(PA, 64'h7);  look(PA, "R4 warm->cold replaces", 64'h7, 1'b0);
        upd(PA, 64'h8);  look(PA, "R4 cold saturates", 64'h8, 1'b0);
        upd(PA, 64'h8);  look(PA, "R4 no wrap after cold", 64'h8, 1'b0);
        upd(PA, 64'h8);  look(PA, "R5 trust again", 64'h8, 1'b1);
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        lk_pc      = PB;
        upd_valid  = 1'b1;
        upd_pc     = PB;
        upd_result = 64'hABCD;
        #1;
        chk(lk_value == 64'h0, "R8 old contents", lk_value, 64'h0);
        @(negedge clk);
        upd_valid = 1'b0;
        #1;
        chk(lk_value == 64'hABCD, "R8 new after edge", lk_value, 64'hABCD);
    endtask

    task automatic t_tag_conflict;
        look(PC, "R9 other tag misses", 64'h0, 1'b0);
        upd(PC, 64'h3);
        look(PC, "R9 new tag allocated", 64'h3, 1'b0);
        look(PA, "R9 old tag evicted", 64'h0, 1'b0);
    endtask

    task automatic t_alias;
        upd(PE, 64'h11);
        upd(PE, 64'h11);
        upd(PE, 64'h11);
        look(PE, "R10 E trusted", 64'h11, 1'b1);
        upd(PD, 64'h22);
        look(PE, "R10 shared counter reset", 64'h11, 1'b0);
        look(PD, "R10 D allocated", 64'h22, 1'b0);
    endtask

    task automatic t_idle_update;
        @(negedge clk);
        upd_valid  = 1'b0;
        upd_pc     = PE;
        upd_result = 64'h99;
        @(negedge clk);
        @(negedge clk);
        look(PE, "R11 idle update ignored", 64'h11, 1'b0);
        upd_pc = PB;
        @(negedge clk);
        look(PB, "R11 idle keeps B", 64'hABCD, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_counter_walk();
        t_same_cycle();
        t_tag_conflict();
        t_alias();
        t_idle_update();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule